// File: doc/BRIEF.md
# Table Write Lane Formatter

This block turns a one-byte table write (a data byte and its byte address) into what a 16-bit multiplexed external bus needs for the data portion of a bus cycle. That is the 16-bit data pattern, its drive enable, the two write strobes (high lane and low lane), the two active-low byte enables and the byte-address line. A bus sequencer supplies the quarter-cycle phase. A write accepted in the first quarter drives its strobes only in the third and fourth quarters. The data stays on the bus for one further quarter, after the strobe has risen.

A 2-bit mode input picks one of three lane policies. Word write pairs an even-address byte with the following odd-address byte. The even byte is parked in a holding register and nothing is written. The odd write then puts both bytes on the bus at once. Byte select copies the byte onto both lanes, always uses the high strobe, and marks the target lane with a byte enable. Byte write also copies the byte onto both lanes, and marks the target lane with the strobe it fires.

Top module: `tw_lane_fmt`

## Requirements
- R1: While reset is low and after it is released, with no write in flight, wrh_n, wrl_n, ub_n and lb_n are 1, ba0 is 0, bus_oe is 0 and bus_dout is 0000h.
- R2: mode 2'b00 selects byte write, 2'b01 selects byte select, and both 2'b10 and 2'b11 select word write. The mode is taken together with the write request.
- R3: In word write mode a write to an even address (addr bit 0 = 0) loads the byte into the holding register. For that whole write, bus_oe stays 0, bus_dout stays 0000h, and no strobe or byte enable goes low.
- R4: In word write mode a write to an odd address drives {new byte, held byte} on bus_dout[15:8] and bus_dout[7:0]. wrh_n is low, wrl_n stays high, and ub_n and lb_n are both low.
- R5: In byte select mode the byte appears on both lanes and wrh_n is low while wrl_n stays high. For an even address lb_n is low and ub_n high; for an odd address ub_n is low and lb_n high.
- R6: In byte write mode the byte appears on both lanes and ub_n and lb_n are both low. wrl_n is low for an even address and wrh_n is low for an odd address, the other strobe staying high.
- R7: ba0 equals addr bit 0 from the second quarter of an accepted write through the first quarter after its fourth quarter. At all other times ba0 is 0.
- R8: q_phase encodes the quarters as 0 = Q1, 1 = Q2, 2 = Q3, 3 = Q4. Strobes and byte enables are low only in the Q3 and Q4 of an accepted write.
- R9: For writes that drive data, bus_oe is 1 and bus_dout holds one value from Q3 through the Q1 that follows the strobe's rising edge. In any other quarter bus_oe is 0.
- R10: The holding register resets to 00h and keeps its contents across mode changes and across non-word writes. An odd word write with no earlier even word write emits 00h on the low lane.
- R11: wr_start is acted on only in a Q1 quarter. A request in any other quarter produces no strobe, no data and no ba0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_phase | input | 2 | Current quarter from the bus sequencer (0..3 = Q1..Q4) |
| wr_start | input | 1 | Write request, taken only in Q1 |
| wr_addr | input | 21 | Byte address of the write |
| wr_byte | input | 8 | Data byte of the write |
| wr_mode | input | 2 | Lane policy select |
| bus_dout | output | 16 | Data pattern for the multiplexed bus |
| bus_oe | output | 1 | Data drive enable (0 = tri-stated) |
| wrh_n | output | 1 | High-lane write strobe, active low |
| wrl_n | output | 1 | Low-lane write strobe, active low |
| ub_n | output | 1 | Upper byte enable, active low |
| lb_n | output | 1 | Lower byte enable, active low |
| ba0 | output | 1 | Byte address bit 0 |

## Verification
The bench builds the block with its default widths: an 8-bit byte lane and a 21-bit address. At these widths the 36h/A5h pairing cases and the all-ones and all-zero byte values can be driven directly. Random frames mix all four mode codes, both address parities and requests that arrive outside Q1, so writes can be chained back to back. Those chains let the holding register carry a byte across byte-select and byte-write traffic before a later odd word write reads it out.

// File: rtl/tw_pkg.sv
// Shared definitions for the table write lane formatter.
// Assumes a four-quarter bus cycle supplied by an external sequencer.
package tw_pkg;
    localparam logic [1:0] QP1 = 2'd0;
    localparam logic [1:0] QP2 = 2'd1;
    localparam logic [1:0] QP3 = 2'd2;
    localparam logic [1:0] QP4 = 2'd3;

    typedef enum logic [1:0] {
        WM_BYTEWR  = 2'd0,
        WM_BYTESEL = 2'd1,
        WM_WORD    = 2'd2
    } wmode_e;

    // Map the raw 2-bit select onto a lane policy; the upper bit alone means word write.
    function automatic wmode_e decode_mode(input logic [1:0] raw);
        if (raw[1])
            return WM_WORD;
        else if (raw[0])
            return WM_BYTESEL;
        else
            return WM_BYTEWR;
    endfunction
endpackage

// File: rtl/tw_capture.sv
// Captures one write request in Q1 and tracks it through Q2..Q4 plus a
// one-quarter data tail. Assumes the sequencer issues at most one request per
// bus cycle; requests seen outside Q1 are dropped.
module tw_capture
    import tw_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        q_phase,
    input  logic              start,
    input  logic              addr_lsb,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [1:0]        mode_in,
    output logic              accept,
    output logic              op_valid,
    output logic              op_tail,
    output logic              op_lsb,
    output logic [BYTE_W-1:0] op_byte,
    output wmode_e            op_mode
);
    assign accept = start && (q_phase == QP1) && !op_valid;

    // Hold the accepted write until the end of Q4, then flag the tail quarter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid <= 1'b0;
            op_tail  <= 1'b0;
            op_lsb   <= 1'b0;
            op_byte  <= '0;
            op_mode  <= WM_BYTEWR;
        end else begin
            op_tail <= op_valid && (q_phase == QP4);
            if (accept) begin
                op_valid <= 1'b1;
                op_lsb   <= addr_lsb;
                op_byte  <= byte_in;
                op_mode  <= decode_mode(mode_in);
            end else if (op_valid && (q_phase == QP4)) begin
                op_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tw_hold.sv
// One-byte holding register used to pair an even word-write byte with the
// following odd one. Assumes load is a single-cycle qualified pulse.
module tw_hold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);
    // Park the even byte; contents survive everything except reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (load)
            dout <= din;
    end
endmodule

// File: rtl/tw_lane_map.sv
// Combinational mapping from the captured write and current quarter onto the
// bus lanes, strobes and byte enables. Assumes op_* are stable for the write.
module tw_lane_map
    import tw_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                q_phase_hi,
    input  logic                op_valid,
    input  logic                op_tail,
    input  logic                op_lsb,
    input  logic [BYTE_W-1:0]   op_byte,
    input  wmode_e              op_mode,
    input  logic [BYTE_W-1:0]   held,
    output logic [2*BYTE_W-1:0] dout,
    output logic                oe,
    output logic                wrh_n,
    output logic                wrl_n,
    output logic                ub_n,
    output logic                lb_n,
    output logic                ba0
);
    logic window;
    logic emits;

    // Decide which lanes carry data and which control lines assert.
    always_comb begin
        window = op_valid && q_phase_hi;
        emits  = !((op_mode == WM_WORD) && !op_lsb);
        oe     = (window || op_tail) && emits;
        dout   = '0;
        if (oe)
            dout = (op_mode == WM_WORD) ? {op_byte, held} : {op_byte, op_byte};
        wrh_n = !(window && emits && ((op_mode != WM_BYTEWR) || op_lsb));
        wrl_n = !(window && (op_mode == WM_BYTEWR) && !op_lsb);
        ub_n  = 1'b1;
        lb_n  = 1'b1;
        if (window && emits) begin
            if (op_mode == WM_BYTESEL) begin
                ub_n = !op_lsb;
                lb_n = op_lsb;
            end else begin
                ub_n = 1'b0;
                lb_n = 1'b0;
            end
        end
        ba0 = (op_valid || op_tail) && op_lsb;
    end
endmodule

// File: rtl/tw_lane_fmt.sv
// Top of the table write lane formatter: request capture, word-pairing
// holding register and lane mapping. Assumes q_phase steps Q1..Q4 per clock.
module tw_lane_fmt
    import tw_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 21,
    localparam int BUS_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        q_phase,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [1:0]        wr_mode,
    output logic [BUS_W-1:0]  bus_dout,
    output logic              bus_oe,
    output logic              wrh_n,
    output logic              wrl_n,
    output logic              ub_n,
    output logic              lb_n,
    output logic              ba0
);
    logic              accept;
    logic              op_valid;
    logic              op_tail;
    logic              op_lsb;
    logic [BYTE_W-1:0] op_byte;
    wmode_e            op_mode;
    logic [BYTE_W-1:0] held;
    logic              hold_load;

    tw_capture #(.BYTE_W(BYTE_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .q_phase(q_phase), .start(wr_start),
        .addr_lsb(wr_addr[0]), .byte_in(wr_byte), .mode_in(wr_mode),
        .accept(accept), .op_valid(op_valid), .op_tail(op_tail),
        .op_lsb(op_lsb), .op_byte(op_byte), .op_mode(op_mode)
    );

    assign hold_load = accept && (decode_mode(wr_mode) == WM_WORD) && !wr_addr[0];

    tw_hold #(.BYTE_W(BYTE_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(hold_load), .din(wr_byte), .dout(held)
    );

    tw_lane_map #(.BYTE_W(BYTE_W)) u_map (
        .q_phase_hi(q_phase[1]), .op_valid(op_valid), .op_tail(op_tail),
        .op_lsb(op_lsb), .op_byte(op_byte), .op_mode(op_mode), .held(held),
        .dout(bus_dout), .oe(bus_oe), .wrh_n(wrh_n), .wrl_n(wrl_n),
        .ub_n(ub_n), .lb_n(lb_n), .ba0(ba0)
    );
endmodule

// File: rtl/tw_lane_fmt_chk.sv
// Property checker for tw_lane_fmt, attached by bind. Observes ports only.
module tw_lane_fmt_chk #(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       q_phase,
    input logic [BUS_W-1:0] bus_dout,
    input logic             bus_oe,
    input logic             wrh_n,
    input logic             wrl_n,
    input logic             ub_n,
    input logic             lb_n
);
    p_strobe_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrh_n || !wrl_n || !ub_n || !lb_n) |-> q_phase[1]);

    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wrh_n && !wrl_n));

    p_strobe_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrh_n || !wrl_n) |-> bus_oe);

    p_q3_runs_to_q4_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_phase == 2'd2 && !wrh_n) |=> !wrh_n);

    p_data_after_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrh_n) |-> (bus_oe && $stable(bus_dout)));

    p_quiet_dout_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_dout == '0));
endmodule

bind tw_lane_fmt tw_lane_fmt_chk #(.BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .q_phase(q_phase), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .wrh_n(wrh_n), .wrl_n(wrl_n), .ub_n(ub_n), .lb_n(lb_n)
);

// File: tb/tw_lane_fmt_bench.sv
module tw_lane_fmt_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  q_phase = 2'd0;
    logic        wr_start = 1'b0;
    logic [20:0] wr_addr = '0;
    logic [7:0]  wr_byte = '0;
    logic [1:0]  wr_mode = '0;
    logic [15:0] bus_dout;
    logic        bus_oe, wrh_n, wrl_n, ub_n, lb_n, ba0;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0]  ref_hold = 8'h00;
    logic        prev_oe = 1'b0;
    logic        prev_act = 1'b0;
    logic        prev_lsb = 1'b0;
    logic [15:0] prev_dout = '0;

    always #5 clk = ~clk;

    tw_lane_fmt u_tw_lane_fmt (
        .clk(clk), .rst_n(rst_n), .q_phase(q_phase), .wr_start(wr_start),
        .wr_addr(wr_addr), .wr_byte(wr_byte), .wr_mode(wr_mode),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .wrh_n(wrh_n), .wrl_n(wrl_n),
        .ub_n(ub_n), .lb_n(lb_n), .ba0(ba0)
    );

    // Packs {oe, wrh_n, wrl_n, ub_n, lb_n, dout} for the write window (Q3/Q4).
    function automatic logic [20:0] exp_win(input logic act, input logic lsb,
                                            input logic [7:0] b, input logic [1:0] m,
                                            input logic [7:0] h);
        if (!act) return {5'b01111, 16'h0000};
        if (m[1]) begin
            if (!lsb) return {5'b01111, 16'h0000};
            return {5'b10100, b, h};
        end
        if (m[0]) return {1'b1, 1'b0, 1'b1, !lsb, lsb, b, b};
        return {1'b1, !lsb, lsb, 2'b00, b, b};
    endfunction

    task automatic chk(input string req, input logic [20:0] act, input logic [20:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [20:0] pins();
        return {bus_oe, wrh_n, wrl_n, ub_n, lb_n, bus_dout};
    endfunction

    // One bus cycle: Q1 (checks tail of previous write), Q2, Q3, Q4.
    task automatic frame(input logic start, input logic stray, input logic [20:0] a,
                         input logic [7:0] b, input logic [1:0] m, input string req);
        logic [20:0] e;
        @(negedge clk);
        q_phase = 2'd0; wr_start = start; wr_addr = a; wr_byte = b; wr_mode = m;
        #2;
        chk("R9 tail", pins(), prev_oe ? {5'b11111, prev_dout} : {5'b01111, 16'h0});
        chk("R7 tail ba0", {20'h0, ba0}, {20'h0, prev_act && prev_lsb});
        e = exp_win(start, a[0], b, m, ref_hold);
        if (start && m[1] && !a[0]) ref_hold = b;
        @(negedge clk);
        q_phase = 2'd1; wr_start = stray; wr_addr = ~a; wr_byte = ~b;
        #2;
        chk("R8 Q2 idle", pins(), {5'b01111, 16'h0});
        chk("R7 ba0 Q2", {20'h0, ba0}, {20'h0, start && a[0]});
        @(negedge clk);
        q_phase = 2'd2;
        #2;
        chk({req, " Q3"}, pins(), e);
        @(negedge clk);
        q_phase = 2'd3; wr_start = 1'b0;
        #2;
        chk({req, " Q4"}, pins(), e);
        chk("R7 ba0 Q4", {20'h0, ba0}, {20'h0, start && a[0]});
        prev_oe = e[20]; prev_dout = e[15:0]; prev_act = start; prev_lsb = a[0];
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        #2;
        chk("R1 in reset", pins(), {5'b01111, 16'h0});
        chk("R1 ba0", {20'h0, ba0}, 21'h0);
        @(negedge clk); rst_n = 1'b1;
        // R10: odd word write straight after reset shows held 00h
        frame(1, 0, 21'h030003, 8'hA5, 2'b10, "R10 reset hold");
        // R3/R4 pairing 36h then A5h -> A536h
        frame(1, 0, 21'h030002, 8'h36, 2'b10, "R3 word even");
        frame(1, 0, 21'h030003, 8'hA5, 2'b10, "R4 word odd");
        // R5 byte select, R6 byte write duplication
        frame(1, 0, 21'h030002, 8'h36, 2'b01, "R5 sel even");
        frame(1, 0, 21'h030003, 8'hA5, 2'b01, "R5 sel odd");
        frame(1, 0, 21'h030002, 8'h36, 2'b00, "R6 bw even");
        frame(1, 0, 21'h030003, 8'hA5, 2'b00, "R6 bw odd");
        // R2: code 11 is word write; R10 hold kept across other modes
        frame(1, 0, 21'h1FFFFE, 8'h5A, 2'b11, "R2 word11 even");
        frame(1, 0, 21'h000004, 8'hFF, 2'b00, "R10 other mode");
        frame(1, 0, 21'h000005, 8'h00, 2'b01, "R10 other mode");
        frame(1, 0, 21'h1FFFFF, 8'hC3, 2'b11, "R10 hold kept");
        // R11: request outside Q1 ignored
        frame(0, 1, 21'h000001, 8'h77, 2'b00, "R11 stray");
        frame(0, 1, 21'h000000, 8'h11, 2'b10, "R11 stray word");
        frame(1, 0, 21'h000001, 8'h99, 2'b10, "R11 hold untouched");
        for (int i = 0; i < 300; i++) begin
            logic st;
            st = ($urandom % 8) != 0;
            frame(st, $urandom % 2, 21'($urandom), 8'($urandom), 2'($urandom), "R2 random");
        end
        frame(0, 0, 21'h0, 8'h0, 2'b00, "R1 idle");
        @(negedge clk); q_phase = 2'd0;
        #2;
        chk("R9 final tail", pins(), {5'b01111, 16'h0});
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule